// File: doc/BRIEF.md
# Dual H-Bridge Control and Fault Supervisor

This block is the digital control core for two independent H-bridges. For each bridge it takes two logic control inputs and turns them into gate enables for the high-side and low-side switch of both half-bridges. A global interface-select input chooses between a two-input interface and a direction/enable interface. An active-low sleep input switches everything off. The analog parts of a motor driver are outside the block. Its current limit, temperature sensor and supply comparator appear here only as digital flags.

Each bridge has its own fault supervisor. An overcurrent flag that stays high past a deglitch window shuts that bridge down. The bridge then comes back by itself after a retry interval. A thermal flag latches the bridge off until a separate cool-down input reports recovery. Supply undervoltage is global. It shuts both bridges down and wipes all internal state. No fault is reported on a status pin; the only visible effect is that the gates turn off.

Every input passes through a two-stage synchronizer. Every half-bridge output goes through a break-before-make stage, so the high-side and low-side switches never conduct together.

Top module: `dual_bridge_ctrl`

## Requirements
- R1: `mode_phen_i` low selects the two-input interface and high selects the direction/enable interface, for both bridges at once. For bridge b, `ctl_i[2b]` is input A (IN1, or ENABLE) and `ctl_i[2b+1]` is input B (IN2, or PHASE).
- R2: Two-input interface, written (A,B) → (OUT1,OUT2), where H is high-side on, L is low-side on and Z is both off: (0,0)→(Z,Z); (0,1)→(L,H); (1,0)→(H,L); (1,1)→(L,L).
- R3: Direction/enable interface: ENABLE=0 gives (L,L) whatever PHASE is. With ENABLE=1, PHASE=1 gives (L,H) and PHASE=0 gives (H,L).
- R4: While the synchronized `sleep_n_i` is low, every gate of both bridges is off. Sleep also clears any overcurrent retry or thermal latch. After reset the block behaves as asleep until `sleep_n_i` high has passed the synchronizer.
- R5: If `ocp_i[b]` stays high for `OCP_DEGLITCH_CYC` consecutive synchronized cycles, bridge b turns off and the other bridge is unaffected. A shorter pulse has no effect.
- R6: After an overcurrent shutdown, bridge b resumes by itself about `RETRY_CYC` cycles after the trip, and not earlier. The default value corresponds to 1 ms at `CLK_HZ`.
- R7: The high-side enable and the low-side enable of a half-bridge are never asserted in the same cycle. Half h of bridge b is bit 2b+h of `gate_hi_o` and `gate_lo_o`, with h=0 for OUT1.
- R8: A half-bridge that moves from one driven state to the opposite one is fully off for exactly `DEAD_CYC` cycles in between.
- R9: `hot_i[b]` latches bridge b off. The latch clears only in a cycle where `cool_i[b]` is high and `hot_i[b]` is low.
- R10: While `uv_i` is high, both bridges are off and all fault state is cleared, so that release of `uv_i` restores operation even after an overcurrent trip or thermal latch.
- R11: When a half is off with no dead time pending, a control change at the pins reaches the gates on the third rising clock edge: two synchronizer stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_phen_i | input | 1 | Interface select: 0 two-input, 1 direction/enable |
| sleep_n_i | input | 1 | Active-low sleep |
| ctl_i | input | 2*NUM_BRIDGES | Control inputs A/B per bridge |
| ocp_i | input | NUM_BRIDGES | Overcurrent flag per bridge |
| hot_i | input | NUM_BRIDGES | Overtemperature flag per bridge |
| cool_i | input | NUM_BRIDGES | Temperature back below threshold minus hysteresis |
| uv_i | input | 1 | Supply undervoltage flag |
| gate_hi_o | output | 2*NUM_BRIDGES | High-side gate enables |
| gate_lo_o | output | 2*NUM_BRIDGES | Low-side gate enables |

## Verification
The bench steps a half-bridge from forward to reverse and counts the off cycles in between. A break-before-make stage off by one would show one dead cycle too many or too few, or an overlap of the two enables. It sends an overcurrent pulse one cycle shorter than the deglitch window and then one of exactly that length. A deglitch counter that trips early or late fails one of the two, and a design that shares the trip between bridges turns off the wrong bridge. It holds the thermal flag high together with the cool-down input, which catches a latch that lets recovery win. It then checks that sleep and undervoltage clear a pending retry or a thermal latch, which a design that only masks the outputs would miss.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

  // Drive state of one half-bridge
  typedef enum logic [1:0] {
    HB_OFF  = 2'd0,
    HB_HIGH = 2'd1,
    HB_LOW  = 2'd2
  } hb_drive_e;

  typedef struct packed {
    hb_drive_e out1;
    hb_drive_e out2;
  } br_cmd_t;

  // a: IN1 / ENABLE, b: IN2 / PHASE
  function automatic br_cmd_t decode_cmd(input logic phen_mode,
                                         input logic a,
                                         input logic b);
    br_cmd_t c;
    if (phen_mode) begin
      if (!a) begin
        c.out1 = HB_LOW;
        c.out2 = HB_LOW;
      end else if (b) begin
        c.out1 = HB_LOW;
        c.out2 = HB_HIGH;
      end else begin
        c.out1 = HB_HIGH;
        c.out2 = HB_LOW;
      end
    end else begin
      unique case ({a, b})
        2'b00:   begin c.out1 = HB_OFF;  c.out2 = HB_OFF;  end
        2'b01:   begin c.out1 = HB_LOW;  c.out2 = HB_HIGH; end
        2'b10:   begin c.out1 = HB_HIGH; c.out2 = HB_LOW;  end
        default: begin c.out1 = HB_LOW;  c.out2 = HB_LOW;  end
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/dbc_sync.sv
module dbc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/dbc_fault_sup.sv
module dbc_fault_sup #(
  parameter int OCP_DEGLITCH_CYC = 200,
  parameter int RETRY_CYC        = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe_i,
  input  logic ocp_i,
  input  logic hot_i,
  input  logic cool_i,
  output logic ok_o
);

  localparam int DW = (OCP_DEGLITCH_CYC > 1) ? $clog2(OCP_DEGLITCH_CYC) : 1;
  localparam int RW = (RETRY_CYC > 1) ? $clog2(RETRY_CYC) : 1;
  localparam logic [DW-1:0] DEG_LAST = DW'(OCP_DEGLITCH_CYC - 1);
  localparam logic [RW-1:0] RET_LAST = RW'(RETRY_CYC - 1);

  logic [DW-1:0] deg_q, deg_d;
  logic [RW-1:0] ret_q, ret_d;
  logic          trip_q, trip_d;
  logic          hot_q, hot_d;

  always_comb begin
    deg_d  = deg_q;
    ret_d  = ret_q;
    trip_d = trip_q;
    hot_d  = hot_q;
    if (wipe_i) begin
      deg_d  = '0;
      ret_d  = '0;
      trip_d = 1'b0;
      hot_d  = 1'b0;
    end else begin
      if (trip_q) begin
        deg_d = '0;
        if (ret_q == RET_LAST) begin
          trip_d = 1'b0;
          ret_d  = '0;
        end else begin
          ret_d = ret_q + RW'(1);
        end
      end else if (ocp_i) begin
        if (deg_q == DEG_LAST) begin
          trip_d = 1'b1;
          deg_d  = '0;
          ret_d  = '0;
        end else begin
          deg_d = deg_q + DW'(1);
        end
      end else begin
        deg_d = '0;
      end
      if (hot_i) begin
        hot_d = 1'b1;
      end else if (cool_i) begin
        hot_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deg_q  <= '0;
      ret_q  <= '0;
      trip_q <= 1'b0;
      hot_q  <= 1'b0;
    end else begin
      deg_q  <= deg_d;
      ret_q  <= ret_d;
      trip_q <= trip_d;
      hot_q  <= hot_d;
    end
  end

  assign ok_o = !trip_q && !hot_q;

endmodule

// File: rtl/dbc_deadband.sv
module dbc_deadband
  import dbc_pkg::*;
#(
  parameter int DEAD_CYC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  hb_drive_e target_i,
  output logic      hi_o,
  output logic      lo_o
);

  localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

  hb_drive_e     cur_q, cur_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cur_d = cur_q;
    cnt_d = (cnt_q != '0) ? cnt_q - CW'(1) : cnt_q;
    if (target_i != cur_q) begin
      if (cur_q != HB_OFF) begin
        cur_d = HB_OFF;
        cnt_d = LOAD;
      end else if (cnt_q == '0) begin
        cur_d = target_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= HB_OFF;
      cnt_q <= '0;
    end else begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign hi_o = (cur_q == HB_HIGH);
  assign lo_o = (cur_q == HB_LOW);

endmodule

// File: rtl/dual_bridge_ctrl.sv
module dual_bridge_ctrl
  import dbc_pkg::*;
#(
  parameter int NUM_BRIDGES      = 2,
  parameter int CLK_HZ           = 100_000_000,
  parameter int OCP_DEGLITCH_CYC = 200,
  parameter int RETRY_CYC        = CLK_HZ / 1000,
  parameter int DEAD_CYC         = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_phen_i,
  input  logic                     sleep_n_i,
  input  logic [2*NUM_BRIDGES-1:0] ctl_i,
  input  logic [NUM_BRIDGES-1:0]   ocp_i,
  input  logic [NUM_BRIDGES-1:0]   hot_i,
  input  logic [NUM_BRIDGES-1:0]   cool_i,
  input  logic                     uv_i,
  output logic [2*NUM_BRIDGES-1:0] gate_hi_o,
  output logic [2*NUM_BRIDGES-1:0] gate_lo_o
);

  localparam int NH     = 2 * NUM_BRIDGES;
  localparam int SYNC_W = 3 + NH + 3 * NUM_BRIDGES;

  logic                   mode_s;
  logic                   sleep_n_s;
  logic                   uv_s;
  logic [NH-1:0]          ctl_s;
  logic [NUM_BRIDGES-1:0] ocp_s;
  logic [NUM_BRIDGES-1:0] hot_s;
  logic [NUM_BRIDGES-1:0] cool_s;
  logic                   halt;
  logic [NUM_BRIDGES-1:0] bridge_ok;

  dbc_sync #(.W(SYNC_W)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({mode_phen_i, sleep_n_i, uv_i, ctl_i, ocp_i, hot_i, cool_i}),
    .q_o   ({mode_s, sleep_n_s, uv_s, ctl_s, ocp_s, hot_s, cool_s})
  );

  assign halt = !sleep_n_s || uv_s;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
    br_cmd_t   cmd;
    hb_drive_e tgt1;
    hb_drive_e tgt2;

    dbc_fault_sup #(
      .OCP_DEGLITCH_CYC (OCP_DEGLITCH_CYC),
      .RETRY_CYC        (RETRY_CYC)
    ) sup_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wipe_i (halt),
      .ocp_i  (ocp_s[b]),
      .hot_i  (hot_s[b]),
      .cool_i (cool_s[b]),
      .ok_o   (bridge_ok[b])
    );

    always_comb begin
      cmd = decode_cmd(mode_s, ctl_s[2*b], ctl_s[2*b+1]);
      if (!halt && bridge_ok[b]) begin
        tgt1 = cmd.out1;
        tgt2 = cmd.out2;
      end else begin
        tgt1 = HB_OFF;
        tgt2 = HB_OFF;
      end
    end

    dbc_deadband #(.DEAD_CYC(DEAD_CYC)) db1_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .target_i (tgt1),
      .hi_o     (gate_hi_o[2*b]),
      .lo_o     (gate_lo_o[2*b])
    );

    dbc_deadband #(.DEAD_CYC(DEAD_CYC)) db2_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .target_i (tgt2),
      .hi_o     (gate_hi_o[2*b+1]),
      .lo_o     (gate_lo_o[2*b+1])
    );
  end

endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
  parameter int NUM_BRIDGES = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2*NUM_BRIDGES-1:0] gate_hi_o,
  input logic [2*NUM_BRIDGES-1:0] gate_lo_o,
  input logic                     sleep_n_s,
  input logic                     uv_s,
  input logic [NUM_BRIDGES-1:0]   bridge_ok
);

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi_o & gate_lo_o) == '0);

  // R4
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n_s |=> (gate_hi_o | gate_lo_o) == '0);

  // R10
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |=> (gate_hi_o | gate_lo_o) == '0);

  for (genvar h = 0; h < 2 * NUM_BRIDGES; h++) begin : g_half
    // R8
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_hi_o[h] |=> !gate_lo_o[h]);
    // R8
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_lo_o[h] |=> !gate_hi_o[h]);
  end

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
    // R5
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bridge_ok[b] |=> (gate_hi_o[2*b+1 -: 2] | gate_lo_o[2*b+1 -: 2]) == 2'b00);
  end

endmodule

bind dual_bridge_ctrl dbc_checker #(.NUM_BRIDGES(NUM_BRIDGES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_hi_o (gate_hi_o),
  .gate_lo_o (gate_lo_o),
  .sleep_n_s (sleep_n_s),
  .uv_s      (uv_s),
  .bridge_ok (bridge_ok)
);

// File: tb/dual_bridge_ctrl_tb_top.sv
module dual_bridge_ctrl_tb_top;

  localparam int NB    = 2;
  localparam int DEG   = 4;
  localparam int RETRY = 60;
  localparam int DEAD  = 3;
  localparam int ZZ = 0, HH = 1, LL = 2;

  logic          clk;
  logic          rst_n;
  logic          mode_phen_i;
  logic          sleep_n_i;
  logic [2*NB-1:0] ctl_i;
  logic [NB-1:0] ocp_i;
  logic [NB-1:0] hot_i;
  logic [NB-1:0] cool_i;
  logic          uv_i;
  logic [2*NB-1:0] gate_hi_o;
  logic [2*NB-1:0] gate_lo_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc_cnt = 0;

  dual_bridge_ctrl #(
    .NUM_BRIDGES      (NB),
    .OCP_DEGLITCH_CYC (DEG),
    .RETRY_CYC        (RETRY),
    .DEAD_CYC         (DEAD)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_phen_i (mode_phen_i),
    .sleep_n_i   (sleep_n_i),
    .ctl_i       (ctl_i),
    .ocp_i       (ocp_i),
    .hot_i       (hot_i),
    .cool_i      (cool_i),
    .uv_i        (uv_i),
    .gate_hi_o   (gate_hi_o),
    .gate_lo_o   (gate_lo_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc_cnt);
      summary();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int half_state(input int idx);
    if (gate_hi_o[idx] && gate_lo_o[idx]) return 3;
    if (gate_hi_o[idx]) return HH;
    if (gate_lo_o[idx]) return LL;
    return ZZ;
  endfunction

  task automatic chk_br(input int b, input int e1, input int e2, input string tag);
    int a1, a2;
    a1 = half_state(2*b);
    a2 = half_state(2*b+1);
    n_chk++;
    if (a1 != e1 || a2 != e2) begin
      n_err++;
      $display("FAIL %s bridge%0d: actual=(%0d,%0d) expected=(%0d,%0d)",
               tag, b, a1, a2, e1, e2);
    end
  endtask

  task automatic set_ctl(input int b, input logic a, input logic c);
    ctl_i[2*b]   = a;
    ctl_i[2*b+1] = c;
  endtask

  // R1 R2: two-input interface, both bridges with different patterns
  task automatic t_two_input();
    mode_phen_i = 1'b0;
    set_ctl(0, 0, 0); set_ctl(1, 1, 1); cyc(12);
    chk_br(0, ZZ, ZZ, "R2 coast");
    chk_br(1, LL, LL, "R2 brake");
    set_ctl(0, 1, 0); set_ctl(1, 0, 1); cyc(12);
    chk_br(0, HH, LL, "R2 forward");
    chk_br(1, LL, HH, "R2 reverse");
    set_ctl(0, 0, 1); set_ctl(1, 1, 0); cyc(12);
    chk_br(0, LL, HH, "R2 reverse");
    chk_br(1, HH, LL, "R2 forward");
    set_ctl(0, 1, 1); set_ctl(1, 0, 0); cyc(12);
    chk_br(0, LL, LL, "R2 brake");
    chk_br(1, ZZ, ZZ, "R1 mode low coast");
  endtask

  // R11: latency from coast
  task automatic t_latency();
    set_ctl(0, 0, 0); cyc(12);
    set_ctl(0, 1, 0);
    cyc(1); chk_br(0, ZZ, ZZ, "R11 edge1");
    cyc(1); chk_br(0, ZZ, ZZ, "R11 edge2");
    cyc(1); chk_br(0, HH, LL, "R11 edge3");
  endtask

  // R1 R3: direction/enable interface
  task automatic t_phase_enable();
    mode_phen_i = 1'b1;
    set_ctl(0, 0, 1); set_ctl(1, 0, 0); cyc(12);
    chk_br(0, LL, LL, "R3 enable0 phase1");
    chk_br(1, LL, LL, "R3 enable0 phase0");
    set_ctl(0, 1, 1); set_ctl(1, 1, 0); cyc(12);
    chk_br(0, LL, HH, "R3 phase1");
    chk_br(1, HH, LL, "R1 mode high phase0");
    mode_phen_i = 1'b0;
  endtask

  // R8 R7: dead time on reversal
  task automatic t_dead();
    int off1, off2, bad_seq, ovl;
    mode_phen_i = 1'b0;
    set_ctl(0, 1, 0); cyc(12);
    off1 = 0; off2 = 0; bad_seq = 0; ovl = 0;
    set_ctl(0, 0, 1);
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (half_state(0) == 3 || half_state(1) == 3) ovl++;
      if (half_state(0) == ZZ) off1++;
      if (half_state(1) == ZZ) off2++;
      if (off1 > 0 && half_state(0) == HH) bad_seq++;
    end
    n_chk++;
    if (off1 != DEAD || off2 != DEAD) begin
      n_err++;
      $display("FAIL R8 dead cycles: actual=(%0d,%0d) expected=(%0d,%0d)", off1, off2, DEAD, DEAD);
    end
    n_chk++;
    if (ovl != 0 || bad_seq != 0) begin
      n_err++;
      $display("FAIL R7 overlap/sequence: actual=%0d expected=0", ovl + bad_seq);
    end
    chk_br(0, LL, HH, "R8 final reverse");
  endtask

  // R5: short overcurrent pulse ignored
  task automatic t_ocp_short();
    int drop;
    set_ctl(0, 1, 0); set_ctl(1, 0, 1); cyc(12);
    drop = 0;
    ocp_i[0] = 1'b1;
    for (int i = 0; i < DEG - 1; i++) begin
      cyc(1);
      if (half_state(0) != HH || half_state(1) != LL) drop++;
    end
    ocp_i[0] = 1'b0;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (half_state(0) != HH || half_state(1) != LL) drop++;
    end
    n_chk++;
    if (drop != 0) begin
      n_err++;
      $display("FAIL R5 short pulse: actual=%0d off cycles expected=0", drop);
    end
  endtask

  // R5 R6: trip and automatic retry
  task automatic t_ocp_trip();
    ocp_i[0] = 1'b1; cyc(DEG); ocp_i[0] = 1'b0;
    cyc(10);
    chk_br(0, ZZ, ZZ, "R5 tripped");
    chk_br(1, LL, HH, "R5 other bridge");
    cyc(40);
    chk_br(0, ZZ, ZZ, "R6 not yet");
    cyc(20);
    chk_br(0, HH, LL, "R6 retry");
  endtask

  // R4: sleep turns all off and clears a pending retry
  task automatic t_sleep();
    ocp_i[0] = 1'b1; cyc(DEG); ocp_i[0] = 1'b0;
    cyc(8);
    chk_br(0, ZZ, ZZ, "R5 tripped again");
    sleep_n_i = 1'b0; cyc(5);
    chk_br(0, ZZ, ZZ, "R4 sleep b0");
    chk_br(1, ZZ, ZZ, "R4 sleep b1");
    sleep_n_i = 1'b1; cyc(12);
    chk_br(0, HH, LL, "R4 sleep clears retry");
    chk_br(1, LL, HH, "R4 wake b1");
  endtask

  // R9: thermal latch
  task automatic t_thermal();
    hot_i[1] = 1'b1; cyc(3); hot_i[1] = 1'b0;
    cyc(10);
    chk_br(1, ZZ, ZZ, "R9 latched");
    chk_br(0, HH, LL, "R9 other bridge");
    hot_i[1] = 1'b1; cool_i[1] = 1'b1; cyc(8);
    chk_br(1, ZZ, ZZ, "R9 clear while hot");
    hot_i[1] = 1'b0; cyc(12);
    chk_br(1, LL, HH, "R9 cleared");
    cool_i[1] = 1'b0;
  endtask

  // R10: undervoltage wipes all fault state
  task automatic t_uv();
    hot_i[1] = 1'b1; ocp_i[0] = 1'b1; cyc(DEG);
    hot_i[1] = 1'b0; ocp_i[0] = 1'b0; cyc(6);
    chk_br(1, ZZ, ZZ, "R9 latched again");
    uv_i = 1'b1; cyc(5);
    chk_br(0, ZZ, ZZ, "R10 uv b0");
    chk_br(1, ZZ, ZZ, "R10 uv b1");
    uv_i = 1'b0; cyc(12);
    chk_br(0, HH, LL, "R10 ocp cleared");
    chk_br(1, LL, HH, "R10 thermal cleared");
  endtask

  initial begin
    rst_n = 1'b0;
    mode_phen_i = 1'b0;
    sleep_n_i = 1'b0;
    ctl_i = '0;
    ocp_i = '0;
    hot_i = '0;
    cool_i = '0;
    uv_i = 1'b0;
    cyc(4);
    chk_br(0, ZZ, ZZ, "R4 reset");
    chk_br(1, ZZ, ZZ, "R4 reset");
    rst_n = 1'b1;
    set_ctl(0, 1, 1);
    cyc(6);
    chk_br(0, ZZ, ZZ, "R4 asleep after reset");
    sleep_n_i = 1'b1;
    cyc(4);
    t_two_input();
    t_latency();
    t_phase_enable();
    t_dead();
    t_ocp_short();
    t_ocp_trip();
    t_sleep();
    t_thermal();
    t_uv();
    summary();
  end

endmodule